// File: doc/BRIEF.md
# Jump-Controlled Cell Shift Register

This block is an 18-stage feedback shift register. It is one module of a cascade of such modules that produces a keystream. Every stage is built as one of two cell kinds, called F and S. A single jump-control input decides, for each stage, whether it acts as a plain shift cell or as a jump cell:

- A plain shift cell copies the previous value of its left neighbour.
- A jump cell also XORs in its own previous value.

The cell kind sets the polarity of that choice. All stages are clocked on every enabled cycle.

The state can be written in parallel. A small key-map stand-in combines nine state bits with a 16-bit key to produce the jump-control bit for the next module. The feedback taps, the cell pattern and the key-map bit indices are parameters. The module at the head of a cascade is used with its jump-control input tied to 0.

Top module: `jc_shift_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` becomes all zeros at that edge.
- R2: When `load` is high (and `rst` low), `state` takes `load_val` at that edge, whatever `en` and `jc_in` are.
- R3: With `rst`, `load` and `en` all low, `state` holds its value across the edge, for either value of `jc_in`.
- R4: The cell pattern for stage indices 17 down to 0 is S S F S S S F S F F F F F F S F S S. An F stage is in jump mode when `jc_in` is 1; an S stage is in jump mode when `jc_in` is 0.
- R5: On an enabled step, stage i (i from 1 to 17) in shift mode becomes old `state[i-1]`. In jump mode it becomes old `state[i-1]` XOR old `state[i]`.
- R6: On an enabled step, stage 0 becomes the XOR of the old state bits selected by the tap mask (default: bits 17 and 10). When stage 0 is in jump mode, its own old value is XORed in as well.
- R7: `jc_out` is combinational. It equals the XOR of state bits 0, 2, 4, 6, 8, 10, 12, 14 and 16 (the default indices), XORed with the parity of all 16 `key` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load strobe |
| load_val | input | 18 | Parallel initial state |
| en | input | 1 | Step enable |
| jc_in | input | 1 | Jump-control input |
| key | input | 16 | Key bits for the key map |
| state | output | 18 | Full register state |
| jc_out | output | 1 | Jump-control bit for the next module |

## Verification
Reset, load, hold and each step show on `state` one edge after the inputs are driven. The bench therefore drives two time units after a rising edge and compares `state` with its own model two time units after the following edge. `jc_out` depends only on the present state and `key`, so it is checked within the same cycle, one time unit after the key is driven. Stepping runs with `jc_in` held at 0, held at 1, toggling every cycle and following a pseudo-random pattern. These runs are mixed with gaps in `en` and mid-run reloads, so that every cell is compared in both modes.

// File: rtl/jc_shift_reg.sv
module jc_shift_reg #(
  parameter int N = 18,
  parameter int KEY_W = 16,
  parameter int KM_N = 9,
  parameter int IDX_W = 5,
  parameter logic [N-1:0] F_MASK = 18'h08BF4,
  parameter logic [N-1:0] TAPS = 18'h20400,
  parameter logic [KM_N*IDX_W-1:0] KM_IDX =
    {5'd16, 5'd14, 5'd12, 5'd10, 5'd8, 5'd6, 5'd4, 5'd2, 5'd0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N-1:0]     load_val,
  input  logic             en,
  input  logic             jc_in,
  input  logic [KEY_W-1:0] key,
  output logic [N-1:0]     state,
  output logic             jc_out
);

  logic [N-1:0] jump_m;
  logic [N-1:0] nxt;
  logic [KM_N-1:0] km_bits;

  assign jump_m = jc_in ? F_MASK : ~F_MASK;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign nxt[0] = (^(state & TAPS)) ^ (jump_m[0] & state[0]);
      end else begin : g_body
        assign nxt[i] = state[i-1] ^ (jump_m[i] & state[i]);
      end
    end
    for (i = 0; i < KM_N; i++) begin : g_km
      assign km_bits[i] = state[KM_IDX[i*IDX_W +: IDX_W]];
    end
  endgenerate

  assign jc_out = (^km_bits) ^ (^key);

  always_ff @(posedge clk) begin
    if (rst)       state <= '0;
    else if (load) state <= load_val;
    else if (en)   state <= nxt;
  end

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> state == '0);

  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(load_val));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(state));

  generate
    for (i = 1; i < N; i++) begin : g_chk
      p_shift_cell_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && en && (jc_in != F_MASK[i])) |=> state[i] == $past(state[i-1]));
      p_jump_cell_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && en && (jc_in == F_MASK[i])) |=>
          state[i] == ($past(state[i-1]) ^ $past(state[i])));
    end
  endgenerate

  p_head_cell_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && en) |=> state[0] == ((^($past(state) & TAPS)) ^
      ((($past(jc_in) == F_MASK[0])) & $past(state[0]))));

endmodule

// File: tb/jc_shift_reg_bench.sv
module jc_shift_reg_bench;
  logic clk = 0;
  logic rst, load, en, jc_in;
  logic [17:0] load_val;
  logic [15:0] key;
  logic [17:0] state;
  logic jc_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [17:0] m;
  logic [15:0] prn = 16'hACE1;

  always #5 clk = ~clk;

  jc_shift_reg u_jc_shift_reg (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .en(en),
    .jc_in(jc_in), .key(key), .state(state), .jc_out(jc_out)
  );

  localparam string PATTERN = "SSFSSSFSFFFFFFSFSS";

  function automatic logic [17:0] step(input logic [17:0] s, input logic j);
    logic [17:0] r;
    for (int i = 0; i < 18; i++) begin
      logic is_f;
      logic jm;
      is_f = (PATTERN[17-i] == "F");
      jm = is_f ? j : !j;
      if (i == 0) r[0] = s[17] ^ s[10] ^ (jm & s[0]);
      else        r[i] = s[i-1] ^ (jm & s[i]);
    end
    return r;
  endfunction

  function automatic logic km(input logic [17:0] s, input logic [15:0] k);
    logic p;
    p = ^k;
    for (int i = 0; i < 18; i += 2) p ^= s[i];
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic run(input int n, input int mode, input bit gap);
    for (int c = 0; c < n; c++) begin
      prn = {prn[14:0], prn[15] ^ prn[13] ^ prn[12] ^ prn[10]};
      case (mode)
        0: jc_in = 0;
        1: jc_in = 1;
        2: jc_in = c[0];
        default: jc_in = prn[3];
      endcase
      en = gap ? prn[7] : 1'b1;
      key = prn ^ 16'(c * 16'h1F3);
      #1;
      check("R7 key map", {31'd0, jc_out}, {31'd0, km(m, key)});
      tick();
      if (en) m = step(m, jc_in);
      check(gap ? "R3/R5/R6 gapped step" : "R4/R5/R6 step", {14'd0, state}, {14'd0, m});
    end
  endtask

  initial begin
    rst = 1; load = 0; en = 0; jc_in = 0; load_val = '0; key = 16'h0001;
    tick();
    check("R1 reset", {14'd0, state}, 32'd0);
    #1 check("R7 reset key parity", {31'd0, jc_out}, 32'd1);
    rst = 0; load = 1; load_val = 18'h2A5C3; en = 0;
    tick();
    check("R2 load", {14'd0, state}, 32'h2A5C3);
    load_val = 18'h13579; en = 1; jc_in = 1;
    tick();
    check("R2 load over enable", {14'd0, state}, 32'h13579);
    m = 18'h13579;
    load = 0; en = 0;
    for (int c = 0; c < 3; c++) begin
      jc_in = c[0];
      tick();
      check("R3 hold", {14'd0, state}, {14'd0, m});
    end
    run(40, 0, 0);
    run(40, 1, 0);
    run(40, 2, 0);
    run(60, 3, 0);
    run(60, 3, 1);
    for (int r = 0; r < 18; r++) begin
      load = 1; load_val = 18'(1 << r); en = 1;
      tick();
      load = 0; m = 18'(1 << r);
      check("R2 reload", {14'd0, state}, {14'd0, m});
      run(4, r % 4, 0);
    end
    rst = 1;
    tick();
    check("R1 reset mid-run", {14'd0, state}, 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule